// File: doc/BRIEF.md
# Single-Cycle Immediate-Add Integer Core

This block is a small processor that completes one instruction on every clock edge. It runs five kinds of instruction: stop, no-operation, load-immediate, a two-register arithmetic/logic group and an add-immediate instruction. The add-immediate instruction adds a 64-bit constant carried in the instruction to a register and updates the condition flags. In one clock cycle the core fetches the bytes at the program counter, reads the register file, computes the result, writes the result back and advances the program counter.

A program is written one byte at a time into the internal instruction store through a load port while reset is held high. When reset is released the core runs. It stops when it reaches a stop instruction or an encoding it does not recognise. Debug outputs show the program counter, the three condition flags and the stopped state. They also give a registered view of any register chosen by a select input.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high, the core clears the program counter to 0, all fifteen registers to 0, the flags to ZF=1, SF=0 and OF=0, and the stopped flag to 0. Bytes written through the load port (`load_en` high, one byte per edge at `load_addr`) are kept across reset.
- R2: Instruction layout: byte 0 holds the opcode in bits 7:4 and the function in bits 3:0. Byte 1 holds the source register id in bits 7:4 and the destination register id in bits 3:0. An 8-byte constant sits in bytes 2 to 9, least significant byte first.
- R3: Load-immediate (opcode 0x3) is 10 bytes long. It writes the constant to the destination register, advances the program counter by 10 and leaves the flags unchanged.
- R4: The register ALU group (opcode 0x6) is 2 bytes long. It computes dest OP src and writes the result to the destination register. The function codes are 0 add, 1 subtract (dest minus src), 2 AND and 3 XOR. The source register is not changed.
- R5: Add-immediate (opcode 0xC, function 0, source field 0xF) is 10 bytes long. It writes dest + constant to the destination register, updates the flags and advances the program counter by 10.
- R6: Flags from the ALU group and add-immediate: ZF is set when the result is zero and SF equals result bit 63. OF is set on signed overflow for add and subtract and is cleared for AND and XOR.
- R7: No-operation (opcode 0x1) is 1 byte long and changes nothing except the program counter.
- R8: Stop (opcode 0x0) sets the stopped flag. From then on the program counter stays at the stop instruction, and the registers and flags do not change until reset.
- R9: An unknown opcode, an ALU function above 3, or add-immediate with a source field other than 0xF or a function other than 0 stops the core as in R8. The faulting instruction changes no register and no flag.
- R10: Register id 0xF as a destination is never written, and no other register changes because of it.
- R11: `dbg_reg_val` shows the register chosen by `dbg_reg_sel` one clock edge after the select is applied. Select 0xF reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; programs are loaded while it is high |
| load_en | input | 1 | Write one byte into the instruction store |
| load_addr | input | $clog2(IMEM_BYTES) | Byte address for the load port |
| load_byte | input | 8 | Byte to store |
| dbg_reg_sel | input | 4 | Register id to observe |
| dbg_reg_val | output | 64 | Registered contents of the selected register |
| dbg_pc | output | $clog2(IMEM_BYTES) | Program counter |
| dbg_zf | output | 1 | Zero flag |
| dbg_sf | output | 1 | Sign flag |
| dbg_of | output | 1 | Overflow flag |
| halted | output | 1 | Core has stopped |

## Verification
Each arithmetic case loads two operands and applies one operation. The operands are chosen so that each add, subtract and add-immediate case lands on exactly one of zero, signed overflow in either direction, a negative result or an ordinary value. This separates a wrong overflow formula, wrong operand order in subtraction, or flags taken from the wrong operation. A constant with a different value in every byte checks that the constant is assembled least significant byte first. Separate short programs cover the cases where no state should change: unchanged flags after a load-immediate, writes to id 0xF, and every kind of faulting encoding. In those programs a later instruction that must never run shows whether the core really froze.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int WORD_W   = 64;
  localparam int REG_ID_W = 4;
  localparam int NUM_REGS = 15;
  localparam int FETCH_B  = 10;

  typedef logic [WORD_W-1:0] word_t;

  localparam logic [3:0] OPC_STOP = 4'h0;
  localparam logic [3:0] OPC_NOP  = 4'h1;
  localparam logic [3:0] OPC_LDI  = 4'h3;
  localparam logic [3:0] OPC_ALU  = 4'h6;
  localparam logic [3:0] OPC_ADDI = 4'hC;

  localparam logic [REG_ID_W-1:0] REG_NONE = 4'hF;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_AND = 2'd2,
    FN_XOR = 2'd3
  } alu_fn_e;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } flags_t;

endpackage

// File: rtl/sc_imem.sv
module sc_imem #(
  parameter int DEPTH   = 256,
  parameter int NBYTES  = 10,
  parameter int AW      = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [7:0]          wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [NBYTES*8-1:0] rd_bytes
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // One read lane per fetched byte; addresses wrap around the store.
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign rd_bytes[g*8 +: 8] = mem[rd_addr + AW'(g)];
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREGS = 15,
  parameter int W     = 64,
  parameter int IDW   = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [IDW-1:0] waddr,
  input  logic [W-1:0]   wdata,
  input  logic [IDW-1:0] raddr_a,
  output logic [W-1:0]   rdata_a,
  input  logic [IDW-1:0] raddr_b,
  output logic [W-1:0]   rdata_b,
  input  logic [IDW-1:0] raddr_d,
  output logic [W-1:0]   rdata_d
);

  logic [W-1:0] regs [NREGS];

  function automatic logic [W-1:0] rd(input logic [IDW-1:0] a);
    return (int'(a) < NREGS) ? regs[a] : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we && (int'(waddr) < NREGS)) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = rd(raddr_a);
  assign rdata_b = rd(raddr_b);
  assign rdata_d = rd(raddr_d);

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  alu_fn_e fn,
  input  word_t   a,
  input  word_t   b,
  output word_t   result,
  output flags_t  flags
);

  localparam int MSB = WORD_W - 1;

  logic ovf;

  always_comb begin
    ovf = 1'b0;
    unique case (fn)
      FN_ADD: begin
        result = b + a;
        ovf    = (a[MSB] == b[MSB]) && (result[MSB] != b[MSB]);
      end
      FN_SUB: begin
        result = b - a;
        ovf    = (a[MSB] != b[MSB]) && (result[MSB] != b[MSB]);
      end
      FN_AND:  result = b & a;
      default: result = b ^ a;
    endcase
  end

  assign flags.zf = (result == '0);
  assign flags.sf = result[MSB];
  assign flags.of = ovf;

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_BYTES = 256
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          load_en,
  input  logic [$clog2(IMEM_BYTES)-1:0] load_addr,
  input  logic [7:0]                    load_byte,
  input  logic [REG_ID_W-1:0]           dbg_reg_sel,
  output logic [WORD_W-1:0]             dbg_reg_val,
  output logic [$clog2(IMEM_BYTES)-1:0] dbg_pc,
  output logic                          dbg_zf,
  output logic                          dbg_sf,
  output logic                          dbg_of,
  output logic                          halted
);

  localparam int PC_W = $clog2(IMEM_BYTES);

  // Architectural state
  logic [PC_W-1:0] pc_q;
  flags_t          flags_q;
  logic            halted_q;

  // Fetch
  logic [FETCH_B*8-1:0] fetch;
  logic [3:0]           f_op, f_fn;
  logic [REG_ID_W-1:0]  f_ra, f_rb;
  word_t                f_const;

  sc_imem #(.DEPTH(IMEM_BYTES), .NBYTES(FETCH_B)) u_imem (
    .clk      (clk),
    .wr_en    (load_en),
    .wr_addr  (load_addr),
    .wr_data  (load_byte),
    .rd_addr  (pc_q),
    .rd_bytes (fetch)
  );

  assign f_op    = fetch[7:4];
  assign f_fn    = fetch[3:0];
  assign f_ra    = fetch[15:12];
  assign f_rb    = fetch[11:8];
  assign f_const = fetch[FETCH_B*8-1:16];

  // Register read
  word_t val_a, val_b, dbg_rdata;
  logic  rf_we;
  word_t alu_res;

  sc_regfile #(.NREGS(NUM_REGS), .W(WORD_W), .IDW(REG_ID_W)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (rf_we),
    .waddr   (f_rb),
    .wdata   (alu_res),
    .raddr_a (f_ra),
    .rdata_a (val_a),
    .raddr_b (f_rb),
    .rdata_b (val_b),
    .raddr_d (dbg_reg_sel),
    .rdata_d (dbg_rdata)
  );

  // Decode
  logic [PC_W-1:0] step;
  logic            stop, do_wr, do_cc;
  alu_fn_e         alu_fn;
  word_t           alu_a, alu_b;

  always_comb begin
    step   = '0;
    stop   = 1'b0;
    do_wr  = 1'b0;
    do_cc  = 1'b0;
    alu_fn = FN_ADD;
    alu_a  = f_const;
    alu_b  = '0;
    unique case (f_op)
      OPC_STOP: stop = 1'b1;
      OPC_NOP:  step = PC_W'(1);
      OPC_LDI: begin
        step  = PC_W'(FETCH_B);
        do_wr = 1'b1;
      end
      OPC_ALU: begin
        if (f_fn[3:2] == 2'b00) begin
          step   = PC_W'(2);
          alu_fn = alu_fn_e'(f_fn[1:0]);
          alu_a  = val_a;
          alu_b  = val_b;
          do_wr  = 1'b1;
          do_cc  = 1'b1;
        end else begin
          stop = 1'b1;
        end
      end
      OPC_ADDI: begin
        if (f_fn == 4'h0 && f_ra == REG_NONE) begin
          step  = PC_W'(FETCH_B);
          alu_b = val_b;
          do_wr = 1'b1;
          do_cc = 1'b1;
        end else begin
          stop = 1'b1;
        end
      end
      default: stop = 1'b1;
    endcase
  end

  // Execute
  flags_t alu_flags;

  sc_alu u_alu (
    .fn     (alu_fn),
    .a      (alu_a),
    .b      (alu_b),
    .result (alu_res),
    .flags  (alu_flags)
  );

  // Write back and PC update
  assign rf_we = !rst && !halted_q && do_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      flags_q  <= '{zf: 1'b1, sf: 1'b0, of: 1'b0};
      halted_q <= 1'b0;
    end else if (!halted_q) begin
      if (stop) begin
        halted_q <= 1'b1;
      end else begin
        pc_q <= pc_q + step;
        if (do_cc) flags_q <= alu_flags;
      end
    end
  end

  always_ff @(posedge clk) begin
    dbg_reg_val <= dbg_rdata;
  end

  assign dbg_pc = pc_q;
  assign dbg_zf = flags_q.zf;
  assign dbg_sf = flags_q.sf;
  assign dbg_of = flags_q.of;
  assign halted = halted_q;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
#(
  parameter int PC_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            halted,
  input logic [PC_W-1:0] pc,
  input logic            zf,
  input logic            sf,
  input logic            of,
  input logic [3:0]      op,
  input logic [3:0]      fn,
  input logic [3:0]      ra
);

  logic known_op;
  assign known_op = (op == OPC_STOP) || (op == OPC_NOP) || (op == OPC_LDI) ||
                    (op == OPC_ALU && fn < 4'd4) ||
                    (op == OPC_ADDI && fn == 4'h0 && ra == REG_NONE);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pc == '0 && zf && !sf && !of && !halted));

  // R8
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc) && $stable({zf, sf, of})));

  // R7
  nop_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && op == OPC_NOP) |=> (pc == $past(pc) + PC_W'(1) && !halted));

  // R3
  ldi_keep_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && op == OPC_LDI) |=>
      (pc == $past(pc) + PC_W'(10) && $stable({zf, sf, of})));

  // R4
  alu_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && op == OPC_ALU && fn < 4'd4) |=> (pc == $past(pc) + PC_W'(2) && !halted));

  // R5
  addi_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && op == OPC_ADDI && fn == 4'h0 && ra == REG_NONE) |=>
      (pc == $past(pc) + PC_W'(10) && !halted));

  // R6
  logic_clears_of_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && op == OPC_ALU && (fn == 4'd2 || fn == 4'd3)) |=> !of);

  // R9
  bad_encoding_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && !known_op) |=> (halted && $stable(pc) && $stable({zf, sf, of})));

endmodule

bind sc_core sc_core_chk #(.PC_W(PC_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .halted (halted),
  .pc     (dbg_pc),
  .zf     (dbg_zf),
  .sf     (dbg_sf),
  .of     (dbg_of),
  .op     (f_op),
  .fn     (f_fn),
  .ra     (f_ra)
);

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;

  localparam int MEM = 256;
  localparam int AW  = $clog2(MEM);
  localparam int NV  = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_en = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [7:0]    load_byte = '0;
  logic [3:0]    dbg_reg_sel = '0;
  logic [63:0]   dbg_reg_val;
  logic [AW-1:0] dbg_pc;
  logic          dbg_zf, dbg_sf, dbg_of, halted;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sc_core #(.IMEM_BYTES(MEM)) u_dut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
    .load_byte(load_byte), .dbg_reg_sel(dbg_reg_sel), .dbg_reg_val(dbg_reg_val),
    .dbg_pc(dbg_pc), .dbg_zf(dbg_zf), .dbg_sf(dbg_sf), .dbg_of(dbg_of),
    .halted(halted)
  );

  // Vector table: kind 0..3 = register ALU function, 4 = add-immediate.
  // For ALU: r1 = A (source), r2 = B (dest). For add-immediate: constant A, r2 = B.
  localparam int VK [NV] = '{0, 0, 1, 1, 1, 2, 3, 3, 4, 4, 4, 4};
  localparam logic [63:0] VA [NV] = '{
    64'd5, 64'd1, 64'd3, 64'd1, 64'd5, 64'hF0F0,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h1234, 64'd10,
    64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF};
  localparam logic [63:0] VB [NV] = '{
    64'd7, 64'h7FFF_FFFF_FFFF_FFFF, 64'd3, 64'h8000_0000_0000_0000, 64'd2, 64'hFF00,
    64'd0, 64'h1234, 64'hFFFF_FFFF_FFFF_FFF6,
    64'd1, 64'h8000_0000_0000_0000, 64'h10};
  localparam logic [63:0] VR [NV] = '{
    64'd12, 64'h8000_0000_0000_0000, 64'd0, 64'h7FFF_FFFF_FFFF_FFFF,
    64'hFFFF_FFFF_FFFF_FFFD, 64'hF000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd0,
    64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDFF};
  // {ZF, SF, OF}
  localparam logic [2:0] VF [NV] = '{
    3'b000, 3'b011, 3'b100, 3'b001, 3'b010, 3'b000,
    3'b010, 3'b100, 3'b100, 3'b011, 3'b001, 3'b000};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_byte(input int addr, input logic [7:0] b);
    @(negedge clk);
    load_en   = 1'b1;
    load_addr = AW'(addr);
    load_byte = b;
  endtask

  task automatic put_word(input int addr, input logic [63:0] v);
    for (int i = 0; i < 8; i++) put_byte(addr + i, v[i*8 +: 8]);
  endtask

  task automatic put_ldi(input int addr, input logic [3:0] rb, input logic [63:0] v);
    put_byte(addr, 8'h30);
    put_byte(addr + 1, {4'hF, rb});
    put_word(addr + 2, v);
  endtask

  task automatic put_addi(input int addr, input logic [3:0] ra, input logic [3:0] rb,
                          input logic [63:0] v);
    put_byte(addr, 8'hC0);
    put_byte(addr + 1, {ra, rb});
    put_word(addr + 2, v);
  endtask

  task automatic put_alu(input int addr, input logic [3:0] fn, input logic [3:0] ra,
                         input logic [3:0] rb);
    put_byte(addr, {4'h6, fn});
    put_byte(addr + 1, {ra, rb});
  endtask

  task automatic begin_prog();
    @(negedge clk);
    rst = 1'b1;
  endtask

  task automatic run_prog();
    @(negedge clk);
    load_en = 1'b0;
    rst     = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  task automatic rd_reg(input logic [3:0] sel, output logic [63:0] v);
    @(negedge clk);
    dbg_reg_sel = sel;
    @(negedge clk);
    v = dbg_reg_val;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    int pc_end;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 reset pc", 64'(dbg_pc), 64'd0);
    chk("R1 reset flags", 64'({dbg_zf, dbg_sf, dbg_of}), 64'b100);
    chk("R1 reset halted", 64'(halted), 64'd0);
    rd_reg(4'd7, v);
    chk("R1 reset reg7", v, 64'd0);

    // Table walk: R2 R4 R5 R6
    for (int k = 0; k < NV; k++) begin
      begin_prog();
      if (VK[k] < 4) begin
        put_ldi(0, 4'd1, VA[k]);
        put_ldi(10, 4'd2, VB[k]);
        put_alu(20, 4'(VK[k]), 4'd1, 4'd2);
        put_byte(22, 8'h00);
        pc_end = 22;
      end else begin
        put_ldi(0, 4'd2, VB[k]);
        put_addi(10, 4'hF, 4'd2, VA[k]);
        put_byte(20, 8'h00);
        pc_end = 20;
      end
      run_prog();
      rd_reg(4'd2, v);
      chk($sformatf("R4/R5/R2 vec%0d result", k), v, VR[k]);
      chk($sformatf("R6 vec%0d flags", k), 64'({dbg_zf, dbg_sf, dbg_of}), 64'(VF[k]));
      chk($sformatf("R8 vec%0d pc", k), 64'(dbg_pc), 64'(pc_end));
      if (VK[k] < 4) begin
        rd_reg(4'd1, v);
        chk($sformatf("R4 vec%0d source kept", k), v, VA[k]);
      end
    end

    // R1: reset after a run clears state
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 rerun reset pc", 64'(dbg_pc), 64'd0);
    chk("R1 rerun reset flags", 64'({dbg_zf, dbg_sf, dbg_of}), 64'b100);
    chk("R1 rerun reset halted", 64'(halted), 64'd0);
    rd_reg(4'd2, v);
    chk("R1 rerun reset reg2", v, 64'd0);

    // R3: load-immediate leaves flags alone
    begin_prog();
    put_ldi(0, 4'd3, 64'd5);
    put_byte(10, 8'h00);
    run_prog();
    rd_reg(4'd3, v);
    chk("R3 ldi value", v, 64'd5);
    chk("R3 ldi flags kept", 64'({dbg_zf, dbg_sf, dbg_of}), 64'b100);
    chk("R3 ldi pc", 64'(dbg_pc), 64'd10);

    // R10 / R11: destination 0xF is discarded
    begin_prog();
    put_ldi(0, 4'hF, 64'h55);
    put_ldi(10, 4'd14, 64'd7);
    put_byte(20, 8'h00);
    run_prog();
    chk("R10 pc after discarded write", 64'(dbg_pc), 64'd20);
    rd_reg(4'd14, v);
    chk("R10 reg14", v, 64'd7);
    for (int r = 0; r < 14; r++) begin
      rd_reg(4'(r), v);
      chk($sformatf("R10 reg%0d untouched", r), v, 64'd0);
    end
    rd_reg(4'hF, v);
    chk("R11 select 0xF reads zero", v, 64'd0);

    // R7 / R8: no-ops then stop, stop holds
    begin_prog();
    put_byte(0, 8'h10);
    put_byte(1, 8'h10);
    put_byte(2, 8'h10);
    put_byte(3, 8'h00);
    run_prog();
    chk("R7 nop pc", 64'(dbg_pc), 64'd3);
    chk("R8 halted", 64'(halted), 64'd1);
    repeat (5) @(negedge clk);
    chk("R8 pc held", 64'(dbg_pc), 64'd3);
    chk("R8 still halted", 64'(halted), 64'd1);

    // R9: unknown opcode
    begin_prog();
    put_byte(0, 8'h10);
    put_byte(1, 8'h90);
    put_ldi(2, 4'd4, 64'd9);
    put_byte(12, 8'h00);
    run_prog();
    chk("R9 bad opcode pc", 64'(dbg_pc), 64'd1);
    chk("R9 bad opcode halted", 64'(halted), 64'd1);
    rd_reg(4'd4, v);
    chk("R9 later insn not run", v, 64'd0);

    // R9: add-immediate with a real source register
    begin_prog();
    put_addi(0, 4'd3, 4'd2, 64'd5);
    put_byte(10, 8'h00);
    run_prog();
    chk("R9 addi bad src pc", 64'(dbg_pc), 64'd0);
    chk("R9 addi bad src halted", 64'(halted), 64'd1);
    rd_reg(4'd2, v);
    chk("R9 addi bad src no write", v, 64'd0);

    // R9: ALU function above 3
    begin_prog();
    put_ldi(0, 4'd1, 64'd1);
    put_alu(10, 4'd5, 4'd1, 4'd1);
    put_byte(12, 8'h00);
    run_prog();
    chk("R9 alu bad fn pc", 64'(dbg_pc), 64'd10);
    chk("R9 alu bad fn flags", 64'({dbg_zf, dbg_sf, dbg_of}), 64'b100);
    rd_reg(4'd1, v);
    chk("R9 alu bad fn no write", v, 64'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule